// File: doc/BRIEF.md
# Prioritised Interrupt Arbiter with Level Mask

This block chooses which of sixteen peripheral interrupt requests, or a dedicated break request, is presented to the processor. Software gives each peripheral source a 4-bit level through a small write port into a bank of level registers. The break source has a fixed level of 15. A rising edge on its input sets a pending flag, and that flag stays set until the break is taken.

In every cycle the block compares the best pending level with a 4-bit mask level. A request is presented only if its level is strictly above the mask. The chosen request appears on a valid/ready vector output, with the vector number as the payload. A transfer happens when valid and ready are both high. In that cycle the winning source receives a one-cycle acknowledge pulse, and on the next clock edge the mask takes the accepted level. Software can also write the mask directly, for example to restore it on exception return.

Back-pressure rules: `vec_valid` and `vec_num` are combinational from the pending requests, the levels and the mask. While `vec_ready` is low, nothing is accepted, no acknowledge is issued, the mask keeps its value and a pending break stays pending. The offered vector may change while `vec_ready` is low if a better request arrives.

Top module: `irq_arbiter`

## Requirements
- R1: After reset the mask level is 15, every source level is 0, no break is pending, and `vec_valid` is low.
- R2: A cycle with `lvl_wr_en` high loads `lvl_wr_data` as the level of source `lvl_wr_idx`. The new level is used from the next cycle.
- R3: A peripheral request is offered only when its level is strictly greater than the current mask. A level-0 source is never offered.
- R4: Among eligible peripheral requests, the highest level wins. On equal levels, the lowest source index wins.
- R5: A peripheral winner's vector number is 64 plus its source index. The break vector number is 11.
- R6: An acceptance is a cycle with `vec_valid` and `vec_ready` both high. In that cycle exactly one acknowledge goes high: bit i of `src_ack` for source i, or `brk_ack` for the break. No acknowledge is high in any other cycle.
- R7: While `vec_ready` is low, no acknowledge is issued and the mask does not change.
- R8: An accepted peripheral request loads its level into the mask on the next clock edge.
- R9: A rising edge of `brk_in` latches a pending break. The pending break is held until accepted, and it is offered whenever the mask is below 15. When offered, it beats every peripheral request, including those at level 15.
- R10: Accepting the break sets the mask to 15 and clears the pending flag.
- R11: A cycle with `mask_wr_en` high loads `mask_wr_data` into the mask on the next edge. If an acceptance happens in the same cycle, the acceptance wins and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 16 | Level request from each peripheral source |
| src_ack | output | 16 | One-cycle acceptance pulse to each source |
| brk_in | input | 1 | Break request, rising-edge detected |
| brk_ack | output | 1 | One-cycle acceptance pulse for the break |
| lvl_wr_en | input | 1 | Level register write strobe |
| lvl_wr_idx | input | 4 | Source index to write |
| lvl_wr_data | input | 4 | Level value to write |
| mask_wr_en | input | 1 | Mask write strobe |
| mask_wr_data | input | 4 | Mask value to write |
| mask_level | output | 4 | Current mask level |
| vec_valid | output | 1 | A vector is offered |
| vec_ready | input | 1 | Consumer takes the offered vector |
| vec_num | output | 8 | Vector number of the offered request |

## Verification
Two actions can fall in the same cycle. A vector can be accepted in the cycle that software writes the mask. Separately, the break can be taken while peripheral requests at level 15 are pending. The bench drives `mask_wr_en` in the same cycle as a handshake. It then checks that the mask holds the accepted level and not the written value. It also raises the break while a higher-indexed peripheral is pending. There it checks that only `brk_ack` pulses and that the mask afterwards reads 15. A further check confirms that lowering the mask does not bring back a consumed break.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W = 4;
  localparam int LVL_MAX = (1 << LVL_W) - 1;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_lvl_bank.sv
module irq_lvl_bank
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 16,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  lvl_t                 wr_data,
  output lvl_t [N_SRC-1:0]     lvl
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lvl[g] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        lvl[g] <= wr_data;
    end
  end

  // R2: a write lands in the addressed register
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> lvl[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 16,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]     req,
  input  lvl_t [N_SRC-1:0]     lvl,
  input  lvl_t                 mask,
  output logic                 found,
  output logic [IDX_W-1:0]     idx,
  output lvl_t                 best
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = mask;
    for (int i = 0; i < N_SRC; i++) begin
      if (req[i] && (lvl[i] > best)) begin
        found = 1'b1;
        best  = lvl[i];
        idx   = IDX_W'(i);
      end
    end
  end

  // R3: a found winner is always above the mask
  always_comb begin
    a_r3_above_mask: assert (!found || (best > mask));
  end
endmodule

// File: rtl/irq_brk_latch.sv
module irq_brk_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_in,
  input  logic take,
  output logic pend
);
  logic brk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      brk_q <= brk_in;
      pend  <= (brk_in && !brk_q) || (pend && !take);
    end
  end

  // R9: pending break stays until taken
  a_r9_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !take) |=> pend);
  // R10: taking the break without a new edge clears it
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !(brk_in && !brk_q)) |=> !pend);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 16,
  parameter int VEC_W = 8,
  parameter int VEC_BASE = 64,
  parameter int BRK_VEC = 11,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_SRC-1:0]     src_req,
  output logic [N_SRC-1:0]     src_ack,
  input  logic                 brk_in,
  output logic                 brk_ack,
  input  logic                 lvl_wr_en,
  input  logic [IDX_W-1:0]     lvl_wr_idx,
  input  logic [LVL_W-1:0]     lvl_wr_data,
  input  logic                 mask_wr_en,
  input  logic [LVL_W-1:0]     mask_wr_data,
  output logic [LVL_W-1:0]     mask_level,
  output logic                 vec_valid,
  input  logic                 vec_ready,
  output logic [VEC_W-1:0]     vec_num
);
  lvl_t [N_SRC-1:0] lvl;
  lvl_t             mask_q, best, win_lvl;
  logic             found, brk_pend, brk_win, accept;
  logic [IDX_W-1:0] win_idx;

  irq_lvl_bank #(.N_SRC(N_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(lvl_wr_en), .wr_idx(lvl_wr_idx),
    .wr_data(lvl_wr_data), .lvl(lvl)
  );

  irq_pick #(.N_SRC(N_SRC)) u_pick (
    .req(src_req), .lvl(lvl), .mask(mask_q),
    .found(found), .idx(win_idx), .best(best)
  );

  irq_brk_latch u_brk (
    .clk(clk), .rst_n(rst_n), .brk_in(brk_in),
    .take(accept && brk_win), .pend(brk_pend)
  );

  assign brk_win   = brk_pend && (mask_q != lvl_t'(LVL_MAX));
  assign vec_valid = brk_win || found;
  assign accept    = vec_valid && vec_ready;
  assign win_lvl   = brk_win ? lvl_t'(LVL_MAX) : best;
  assign brk_ack   = accept && brk_win;

  always_comb begin
    if (!vec_valid)   vec_num = '0;
    else if (brk_win) vec_num = VEC_W'(BRK_VEC);
    else              vec_num = VEC_W'(VEC_BASE) + VEC_W'(win_idx);
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_ack
    assign src_ack[g] = accept && !brk_win && (win_idx == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mask_q <= lvl_t'(LVL_MAX);
    else if (accept)     mask_q <= win_lvl;
    else if (mask_wr_en) mask_q <= mask_wr_data;
  end
  assign mask_level = mask_q;

  // R6: at most one acknowledge, and only on a handshake
  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({src_ack, brk_ack}));
  a_r6_only_on_hs: assert property (@(posedge clk) disable iff (!rst_n)
    ((|src_ack) || brk_ack) |-> (vec_valid && vec_ready));
  // R7: no acknowledge under back-pressure
  a_r7_no_ack_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_ready |-> ((src_ack == '0) && !brk_ack));
  // R8 / R10: mask takes accepted level
  a_r8_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> mask_level == $past(win_lvl));
  // R11: mask moves only by acceptance or write
  a_r11_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !mask_wr_en) |=> $stable(mask_level));
endmodule

// File: tb/test_irq_arbiter.sv
module test_irq_arbiter;
  logic        clk = 0, rst_n = 0;
  logic [15:0] src_req = '0, src_ack;
  logic        brk_in = 0, brk_ack;
  logic        lvl_wr_en = 0, mask_wr_en = 0, vec_valid, vec_ready = 0;
  logic [3:0]  lvl_wr_idx = '0, lvl_wr_data = '0, mask_wr_data = '0, mask_level;
  logic [7:0]  vec_num;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  irq_arbiter i_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_ack(src_ack),
    .brk_in(brk_in), .brk_ack(brk_ack), .lvl_wr_en(lvl_wr_en),
    .lvl_wr_idx(lvl_wr_idx), .lvl_wr_data(lvl_wr_data),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .mask_level(mask_level), .vec_valid(vec_valid), .vec_ready(vec_ready),
    .vec_num(vec_num)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic wlvl(input int i, input int l);
    @(negedge clk); lvl_wr_en = 1; lvl_wr_idx = 4'(i); lvl_wr_data = 4'(l);
    @(negedge clk); lvl_wr_en = 0; #2;
  endtask

  task automatic wmask(input int v);
    @(negedge clk); mask_wr_en = 1; mask_wr_data = 4'(v);
    @(negedge clk); mask_wr_en = 0; #2;
  endtask

  task automatic brk_pulse();
    @(negedge clk); brk_in = 1;
    @(negedge clk); brk_in = 0; #2;
  endtask

  task automatic t_reset();
    src_req = '1; #2;
    eq("R1 mask after reset", mask_level, 15);
    eq("R1 no vector after reset", vec_valid, 0);
    src_req = '0;
  endtask

  task automatic t_pick();
    wlvl(3, 5); wlvl(7, 9); wlvl(9, 9);
    wmask(0);
    eq("R11 mask write", mask_level, 0);
    src_req = 16'h0008; #1;
    eq("R2 level used / R5 vector src3", vec_num, 67);
    src_req = 16'h0288; #1;
    eq("R4 tie lowest index wins", vec_num, 71);
    src_req = 16'h0001; #1;
    eq("R3 level 0 never offered", vec_valid, 0);
  endtask

  task automatic t_backpressure();
    src_req = 16'h0080; vec_ready = 0; #1;
    eq("R7 valid while stalled", vec_valid, 1);
    eq("R7 no ack while stalled", src_ack, 0);
    @(negedge clk); #2;
    eq("R7 mask unchanged", mask_level, 0);
    vec_ready = 1; #1;
    eq("R6 ack to source 7", src_ack, 16'h0080);
    eq("R6 no break ack", brk_ack, 0);
    @(negedge clk); #2;
    eq("R8 mask takes level", mask_level, 9);
    src_req = 16'h0088; #1;
    eq("R3 equal level not offered", vec_valid, 0);
    src_req = '0; vec_ready = 0;
  endtask

  task automatic t_collide();
    wmask(0);
    @(negedge clk);
    src_req = 16'h0008; vec_ready = 1; mask_wr_en = 1; mask_wr_data = 4'd2; #1;
    eq("R6 ack src3 in collision", src_ack, 16'h0008);
    @(negedge clk); mask_wr_en = 0; src_req = '0; vec_ready = 0; #2;
    eq("R11 acceptance beats write", mask_level, 5);
  endtask

  task automatic t_break();
    wmask(2);
    brk_pulse();
    src_req = 16'h0080; #1;
    eq("R9 break offered", vec_valid, 1);
    eq("R5 break vector", vec_num, 11);
    @(negedge clk); @(negedge clk); #2;
    eq("R9 break held", vec_num, 11);
    vec_ready = 1; #1;
    eq("R9 break ack", brk_ack, 1);
    eq("R9 no peripheral ack", src_ack, 0);
    @(negedge clk); vec_ready = 0; src_req = '0; #2;
    eq("R10 mask 15 after break", mask_level, 15);
    wmask(0);
    eq("R10 break cleared", vec_valid, 0);
  endtask

  task automatic t_break_masked();
    wmask(15);
    vec_ready = 1;
    brk_pulse();
    eq("R9 break blocked at mask 15", vec_valid, 0);
    wmask(14);
    eq("R9 break taken after unmask", brk_ack, 1);
    @(negedge clk); vec_ready = 0; #2;
    eq("R10 mask 15", mask_level, 15);
  endtask

  task automatic t_top_tie();
    wlvl(2, 15); wlvl(5, 15);
    wmask(0);
    src_req = 16'h0024; #1;
    eq("R4 level 15 tie", vec_num, 66);
    src_req = '0;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_pick();
    t_backpressure();
    t_collide();
    t_break();
    t_break_masked();
    t_top_tie();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule